// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the transmit and receive error counters of a CAN controller and derives the node's fault confinement state from them. The protocol engine reports each error or success event as an amount to add to or subtract from a counter. The block applies these amounts, saturating where needed, and moves the node between three states: error active, error passive and bus off.

While the node is in bus off, the event inputs are set aside. The transmit counter then serves as the upper stage of a recovery counter. A small run counter, fed by per-bit-time samples of the bus, counts consecutive recessive bits. Each complete run of eleven adds one to the transmit counter. When 128 such runs have been seen, the node returns to error active with both counters at zero.

While the host is in freeze mode, it may load both counters. A write is held in a host-side shadow register. It reaches the live counters through a toggle request and acknowledge handshake, with two-flop synchronizers in each direction, so the new value appears a few cycles later. The host can poll the counter outputs to see when the write has taken effect.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters read 0, the state code is 2'b00 and the bus-off pulse is low.
- R2: The state code is 2'b00 for error active, 2'b01 for error passive and 2'b10 for bus off; 2'b11 never appears. Outside bus off, the state is error passive whenever either counter is 128 or more.
- R3: Once both counters are 127 or less, an error-passive node reads error active again.
- R4: If a transmit increment would take the transmit counter above 255, then on the next clock the state becomes bus off, the transmit counter reads 0 and `busoff_irq` is high for exactly one cycle.
- R5: In bus off, every run of 11 consecutive recessive samples (`bit_tick` high with `bus_lvl` = 1) adds 1 to the transmit counter. The increment and decrement inputs have no effect, and the receive counter does not change.
- R6: In bus off, a dominant sample (`bus_lvl` = 0) arriving before a run of 11 is complete restarts the run count and leaves the transmit counter unchanged.
- R7: When the transmit counter would reach 128 in bus off, the state becomes error active and both counters read 0.
- R8: An increment arriving with `ack_err` high is applied to the transmit counter in error active and ignored in error passive.
- R9: A decrement never takes a counter below 0. The receive counter saturates at 255.
- R10: A host write with `frz` high loads both counters. The new values do not appear at once, only after the handshake delay. A write with `frz` low changes nothing.
- R11: While a previous write is still in flight, a new host write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_can | input | 1 | Counter-domain clock |
| clk_host | input | 1 | Host-domain clock for the write path |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| tx_inc | input | AMT_W | Amount to add to the transmit counter (0 = none) |
| tx_dec | input | AMT_W | Amount to subtract from the transmit counter |
| rx_inc | input | AMT_W | Amount to add to the receive counter |
| rx_dec | input | AMT_W | Amount to subtract from the receive counter |
| ack_err | input | 1 | The current transmit increment is due to an acknowledge error |
| bit_tick | input | 1 | One strobe per bit time; `bus_lvl` is valid |
| bus_lvl | input | 1 | Sampled bus level, 1 = recessive |
| frz | input | 1 | Host is in freeze mode |
| wr_en | input | 1 | Host write strobe (host domain) |
| wr_tec | input | CNT_W | Value to load into the transmit counter |
| wr_rec | input | CNT_W | Value to load into the receive counter |
| tec | output | CNT_W | Transmit error counter |
| rec | output | CNT_W | Receive error counter |
| fc_state | output | 2 | Fault confinement state code |
| busoff_irq | output | 1 | One-cycle pulse on entry to bus off |

## Verification
A wrong run count or a missed wrap in bus off changes neither the state nor the outputs until recovery. It then shows as a transmit counter that lags or leads the expected value, or as a return to error active after the wrong number of recessive bits, up to about 1400 bit times later. A wrong saturation or passive threshold shows on the next clock, as an off counter value or state code. A broken handshake shows as a write that never lands, lands at once, or lets a second write through within a few tens of cycles.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W      = 8,
  parameter int AMT_W      = 4,
  parameter int RUN_LEN    = 11,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk_can,
  input  logic             clk_host,
  input  logic             rst_n,
  input  logic [AMT_W-1:0] tx_inc,
  input  logic [AMT_W-1:0] tx_dec,
  input  logic [AMT_W-1:0] rx_inc,
  input  logic [AMT_W-1:0] rx_dec,
  input  logic             ack_err,
  input  logic             bit_tick,
  input  logic             bus_lvl,
  input  logic             frz,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_tec,
  input  logic [CNT_W-1:0] wr_rec,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       fc_state,
  output logic             busoff_irq
);
  localparam int SW = CNT_W + 1;
  localparam int RW = $clog2(RUN_LEN);
  localparam logic [RW-1:0]    RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] RECOV    = CNT_W'(RECOV_RUNS);

  logic             busoff;
  logic [RW-1:0]    run;
  logic             req, ack_s1, ack_s2;
  logic             req_s1, req_s2, req_s3;
  logic [CNT_W-1:0] aux_tec, aux_rec;

  wire busy  = req ^ ack_s2;
  wire apply = req_s2 ^ req_s3;
  wire passive = tec[CNT_W-1] | rec[CNT_W-1];
  assign fc_state = {busoff, passive & ~busoff};

  wire [AMT_W-1:0] tx_add = (ack_err && passive) ? '0 : tx_inc;
  wire [SW-1:0]    tsum   = SW'(tec) + SW'(tx_add);
  wire [CNT_W-1:0] tnext  = (tsum[CNT_W-1:0] >= CNT_W'(tx_dec)) ?
                            tsum[CNT_W-1:0] - CNT_W'(tx_dec) : '0;
  wire [SW-1:0]    rsum   = SW'(rec) + SW'(rx_inc);
  wire [CNT_W-1:0] rsat   = rsum[CNT_W] ? '1 : rsum[CNT_W-1:0];
  wire [CNT_W-1:0] rnext  = (rsat >= CNT_W'(rx_dec)) ? rsat - CNT_W'(rx_dec) : '0;
  wire [CNT_W-1:0] tec_up = tec + CNT_W'(1);

  always_ff @(posedge clk_host or negedge rst_n)
    if (!rst_n) begin
      req <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
      aux_tec <= '0; aux_rec <= '0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (wr_en && frz && !busy) begin
        aux_tec <= wr_tec;
        aux_rec <= wr_rec;
        req     <= ~req;
      end
    end

  always_ff @(posedge clk_can or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
    end else begin
      req_s1 <= req; req_s2 <= req_s1; req_s3 <= req_s2;
    end

  always_ff @(posedge clk_can or negedge rst_n)
    if (!rst_n) begin
      tec <= '0; rec <= '0; busoff <= 1'b0; run <= '0; busoff_irq <= 1'b0;
    end else begin
      busoff_irq <= 1'b0;
      if (apply) begin
        tec <= aux_tec;
        rec <= aux_rec;
      end else if (busoff) begin
        if (bit_tick) begin
          if (!bus_lvl) run <= '0;
          else if (run == RUN_LAST) begin
            run <= '0;
            if (tec_up == RECOV) begin
              busoff <= 1'b0; tec <= '0; rec <= '0;
            end else tec <= tec_up;
          end else run <= run + RW'(1);
        end
      end else if (tsum[CNT_W]) begin
        busoff <= 1'b1; busoff_irq <= 1'b1; tec <= '0; run <= '0; rec <= rnext;
      end else begin
        tec <= tnext;
        rec <= rnext;
      end
    end

  p_code_legal_r2: assert property (@(posedge clk_can) disable iff (!rst_n)
    fc_state != 2'b11);
  p_irq_in_busoff_r4: assert property (@(posedge clk_can) disable iff (!rst_n)
    busoff_irq |-> (fc_state == 2'b10 && tec == '0));
  p_irq_single_r4: assert property (@(posedge clk_can) disable iff (!rst_n)
    busoff_irq |=> !busoff_irq);
  p_busoff_rec_hold_r5: assert property (@(posedge clk_can) disable iff (!rst_n)
    (busoff && $past(busoff) && !$past(apply)) |-> $stable(rec));
  p_busoff_step_r6: assert property (@(posedge clk_can) disable iff (!rst_n)
    (busoff && $past(busoff) && !$past(apply)) |-> (tec == $past(tec) || tec == $past(tec) + CNT_W'(1)));
  p_recover_clear_r7: assert property (@(posedge clk_can) disable iff (!rst_n)
    $fell(busoff) |-> (tec == '0 && rec == '0));
  p_shadow_hold_r11: assert property (@(posedge clk_host) disable iff (!rst_n)
    busy |=> ($stable(aux_tec) && $stable(aux_rec)));
endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk_can = 1'b0, clk_host = 1'b0, rst_n = 1'b0;
  logic [3:0] tx_inc = '0, tx_dec = '0, rx_inc = '0, rx_dec = '0;
  logic ack_err = 1'b0, bit_tick = 1'b0, bus_lvl = 1'b1, frz = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_tec = '0, wr_rec = '0;
  logic [7:0] tec, rec;
  logic [1:0] fc_state;
  logic busoff_irq;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk_can = ~clk_can;
  always #15 clk_host = ~clk_host;

  can_fault_conf uut (.clk_can(clk_can), .clk_host(clk_host), .rst_n(rst_n),
    .tx_inc(tx_inc), .tx_dec(tx_dec), .rx_inc(rx_inc), .rx_dec(rx_dec),
    .ack_err(ack_err), .bit_tick(bit_tick), .bus_lvl(bus_lvl), .frz(frz),
    .wr_en(wr_en), .wr_tec(wr_tec), .wr_rec(wr_rec), .tec(tec), .rec(rec),
    .fc_state(fc_state), .busoff_irq(busoff_irq));

  // {tx_inc, tx_dec, rx_inc, rx_dec, ack_err, exp_tec, exp_rec, exp_state}
  localparam logic [34:0] VEC [9] = '{
    {4'd0, 4'd0, 4'd8, 4'd0, 1'b0, 8'd0,  8'd8, 2'b00},
    {4'd0, 4'd0, 4'd0, 4'd1, 1'b0, 8'd0,  8'd7, 2'b00},
    {4'd0, 4'd0, 4'd0, 4'd9, 1'b0, 8'd0,  8'd0, 2'b00},  // R9 floor
    {4'd8, 4'd0, 4'd0, 4'd0, 1'b0, 8'd8,  8'd0, 2'b00},
    {4'd8, 4'd0, 4'd0, 4'd0, 1'b1, 8'd16, 8'd0, 2'b00},  // R8 active
    {4'd0, 4'd1, 4'd0, 4'd0, 1'b0, 8'd15, 8'd0, 2'b00},
    {4'd0, 4'd15,4'd3, 4'd0, 1'b0, 8'd0,  8'd3, 2'b00},  // R9 floor
    {4'd0, 4'd0, 4'd5, 4'd2, 1'b0, 8'd0,  8'd6, 2'b00},
    {4'd0, 4'd0, 4'd0, 4'd6, 1'b0, 8'd0,  8'd0, 2'b00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [3:0] ti, td, ri, rd, input logic ae);
    tx_inc = ti; tx_dec = td; rx_inc = ri; rx_dec = rd; ack_err = ae;
    @(negedge clk_can);
    tx_inc = '0; tx_dec = '0; rx_inc = '0; rx_dec = '0; ack_err = 1'b0;
  endtask

  task automatic ticks(input int n, input logic lvl);
    bit_tick = 1'b1; bus_lvl = lvl;
    repeat (n) @(negedge clk_can);
    bit_tick = 1'b0; bus_lvl = 1'b1;
  endtask

  task automatic host_wr(input logic f, input logic [7:0] t, input logic [7:0] r);
    @(negedge clk_host);
    frz = f; wr_en = 1'b1; wr_tec = t; wr_rec = r;
    @(negedge clk_host);
    wr_en = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk_can) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_can);
    rst_n = 1'b1;
    @(negedge clk_can);
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);
    chk("R1 state", fc_state, 0); chk("R1 irq", busoff_irq, 0);

    for (int i = 0; i < 9; i++) begin
      ev(VEC[i][34:31], VEC[i][30:27], VEC[i][26:23], VEC[i][22:19], VEC[i][18]);
      chk("R9 vec tec", tec, VEC[i][17:10]);
      chk("R9 vec rec", rec, VEC[i][9:2]);
      chk("R2 vec state", fc_state, VEC[i][1:0]);
    end

    for (int i = 0; i < 15; i++) ev(0, 0, 8, 0, 0);
    chk("R2 rec 120", rec, 120); chk("R2 below", fc_state, 0);
    ev(0, 0, 8, 0, 0);
    chk("R2 rec 128 passive", fc_state, 1);
    for (int i = 0; i < 9; i++) ev(0, 0, 15, 0, 0);
    chk("R9 rec sat", rec, 255);
    for (int i = 0; i < 8; i++) ev(0, 0, 0, 15, 0);
    chk("R3 rec 135", rec, 135); chk("R3 still passive", fc_state, 1);
    ev(0, 0, 0, 8, 0);
    chk("R3 rec 127", rec, 127); chk("R3 active", fc_state, 0);

    for (int i = 0; i < 9; i++) ev(15, 0, 0, 0, 0);
    chk("R2 tec 135", tec, 135); chk("R2 tec passive", fc_state, 1);
    ev(8, 0, 0, 0, 1);
    chk("R8 ack ignored", tec, 135);
    for (int i = 0; i < 8; i++) ev(15, 0, 0, 0, 0);
    chk("R4 tec 255", tec, 255);
    ev(1, 0, 0, 0, 0);
    chk("R4 busoff", fc_state, 2); chk("R4 tec0", tec, 0); chk("R4 irq", busoff_irq, 1);
    @(negedge clk_can);
    chk("R4 irq pulse", busoff_irq, 0);

    ev(8, 0, 8, 0, 0);
    chk("R5 tec events ignored", tec, 0); chk("R5 rec hold", rec, 127);
    ticks(10, 1'b1); ticks(1, 1'b0);
    chk("R6 dominant reset", tec, 0);
    ticks(10, 1'b1);
    chk("R6 run restarted", tec, 0);
    ticks(1, 1'b1);
    chk("R5 one run", tec, 1); chk("R5 rec", rec, 127);
    ticks(126 * 11, 1'b1);
    chk("R5 tec 127", tec, 127); chk("R5 still busoff", fc_state, 2);
    ticks(10, 1'b1);
    chk("R7 not yet", fc_state, 2);
    ticks(1, 1'b1);
    chk("R7 active", fc_state, 0); chk("R7 tec", tec, 0); chk("R7 rec", rec, 0);

    host_wr(1'b0, 8'd77, 8'd66);
    repeat (20) @(negedge clk_can);
    chk("R10 no freeze tec", tec, 0); chk("R10 no freeze rec", rec, 0);

    host_wr(1'b1, 8'd200, 8'd50);
    @(negedge clk_can);
    chk("R10 delayed", tec, 0);
    repeat (20) @(negedge clk_can);
    chk("R10 tec landed", tec, 200); chk("R10 rec landed", rec, 50);
    chk("R2 written passive", fc_state, 1);

    repeat (10) @(negedge clk_host);
    host_wr(1'b1, 8'd10, 8'd20);
    host_wr(1'b1, 8'd99, 8'd99);
    repeat (40) @(negedge clk_can);
    chk("R11 first kept tec", tec, 10); chk("R11 first kept rec", rec, 20);
    chk("R3 after write", fc_state, 0);
    frz = 1'b0;
    report();
  end
endmodule